// File: doc/BRIEF.md
# Parity-Group Self-Checking Output Checker

This block watches a combinational function whose N outputs travel with G predicted check bits. Each output is assigned to exactly one parity group. The check bit of a group must equal the exclusive-OR of the outputs that belong to that group. Because the check bits are simply appended to the unchanged outputs, the downstream logic uses the outputs directly and never decodes them.

For every group, the block recomputes the parity and forms a dual-rail pair, {recomputed parity, inverted check bit}. A consistent group produces 01 or 10. A mismatched group produces 00 or 11. The group pairs are merged through a balanced tree of two-rail cells into one dual-rail result. A cell passes a valid codeword only when both of its input pairs are valid, and an invalid pair always propagates. An error flag is raised when the merged pair is 00 or 11. A parameter selects whether that flag is registered or combinational.

The group map is a parameter, one index per output. At elaboration the block stops with an error if any index is out of range or any group has no members. Two settings mark the ends of the range. Placing all outputs in one group gives plain single-bit parity. Giving each output its own group gives duplicate-and-compare.

Top module: `pgroup_checker`

## Requirements
- R1: When every check bit equals the XOR of the outputs mapped to its group, `rail_out` is 01 or 10 and the error flag is 0.
- R2: Inverting any single functional output of a correct codeword makes `rail_out` 00 or 11 and raises the error flag.
- R3: Inverting any single check bit of a correct codeword makes `rail_out` 00 or 11 and raises the error flag.
- R4: Inverting two bits that both belong to the same group leaves the error undetected: `rail_out` stays 01 or 10 and the flag stays 0. A group consists of its outputs plus its check bit.
- R5: Inverting one bit in each of two different groups is detected: `rail_out` becomes 00 or 11 and the flag rises.
- R6: `rail_out` is 01 or 10 exactly when all groups are consistent, and 00 or 11 otherwise. `err_flag` is 1 exactly when `rail_out` is 00 or 11.
- R7: With `REG_OUT`=1, `err_flag` shows the result for the inputs present at the previous rising clock edge. A low `rst_n` sampled at a rising edge clears it to 0, and it stays 0 for as long as `rst_n` stays low.
- R8: When each output forms its own group, the flag equals 1 exactly when some output differs from its own check bit. With `REG_OUT`=0 the flag follows the inputs without any clock.
- R9: When there is a single group holding all outputs, its pair drives `rail_out` directly. The flag equals 1 exactly when the XOR of all outputs differs from the single check bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| func_out | input | N_OUT | Functional outputs under check |
| check_in | input | N_GRP | Predicted check bits, one per group |
| rail_out | output | 2 | Merged dual-rail result (01/10 valid, 00/11 error) |
| err_flag | output | 1 | Error indication, registered when REG_OUT=1 |

## Verification
On every clock, the assertions check three things. The merged pair must agree with a parity recomputation from the ports. Any single flip of an output or a check bit, starting from a valid state, must produce an invalid pair. The registered flag must follow the previous cycle's pair and must read 0 on the first cycle after reset.

Some behaviour only the bench scenarios can show. These are the blind spot for two flips inside one group, the detection of flips spread across two groups, and the behaviour of the two extreme configurations. The bench shows these through exhaustive sweeps of correct codewords, of single flips and of double flips.

// File: rtl/pgc_pkg.sv
// Shared dual-rail type and helpers for the parity-group checker.
// Assumes the pair encoding {hi, lo}: 01 and 10 are valid, 00 and 11 are not.
package pgc_pkg;

    typedef logic [1:0] rail_t;

    // Returns 1 when a dual-rail pair carries a valid codeword.
    function automatic logic rail_valid(input rail_t r);
        return r[1] ^ r[0];
    endfunction

endpackage

// File: rtl/pgc_group_parity.sv
// Recomputes the parity of one group and encodes it as a dual-rail pair.
// Assumes MEMBERS marks the outputs of this group and has at least one bit set.
module pgc_group_parity
    import pgc_pkg::*;
#(
    parameter int             N_IN    = 8,
    parameter logic [N_IN-1:0] MEMBERS = '1
) (
    input  logic [N_IN-1:0] func_in,
    input  logic            chk_in,
    output rail_t           pair
);

    logic par;

    // Parity over the member outputs only.
    always_comb begin
        par = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (MEMBERS[i]) par = par ^ func_in[i];
        end
    end

    // Pair is {recomputed parity, inverted check bit}.
    assign pair = {par, ~chk_in};

endmodule

// File: rtl/pgc_rail_cell.sv
// Two-rail checker cell: the output is valid only when both inputs are valid.
// Assumes the pgc_pkg pair encoding; an invalid input always yields 00 or 11.
module pgc_rail_cell
    import pgc_pkg::*;
(
    input  rail_t a,
    input  rail_t b,
    output rail_t y
);

    // Cross-coupled AND-OR pair of the two-rail cell.
    always_comb begin
        y[1] = (a[1] & b[1]) | (a[0] & b[0]);
        y[0] = (a[1] & b[0]) | (a[0] & b[1]);
    end

endmodule

// File: rtl/pgc_rail_tree.sv
// Balanced reduction of N_LEAF dual-rail pairs through two-rail cells.
// Uses heap indexing: leaves sit at N_LEAF-1 .. 2*N_LEAF-2, node i merges
// nodes 2i+1 and 2i+2. With one leaf, the leaf itself is the root.
module pgc_rail_tree
    import pgc_pkg::*;
#(
    parameter int N_LEAF = 3
) (
    input  logic [2*N_LEAF-1:0] leaves,
    output rail_t               root
);

    localparam int N_NODE = 2 * N_LEAF - 1;

    rail_t node [N_NODE];

    genvar j;
    genvar k;
    generate
        for (j = 0; j < N_LEAF; j++) begin : g_leaf
            assign node[N_LEAF-1+j] = leaves[2*j +: 2];
        end
        for (k = 0; k < N_LEAF - 1; k++) begin : g_cell
            pgc_rail_cell u_cell (
                .a (node[2*k+1]),
                .b (node[2*k+2]),
                .y (node[k])
            );
        end
    endgenerate

    assign root = node[0];

endmodule

// File: rtl/pgroup_checker.sv
// Self-checking output checker for a parity-group code.
// Assumes GROUP_MAP packs one GIDX_W-bit group index per output, with output i
// at bits [i*GIDX_W +: GIDX_W]. Every group must own at least one output.
module pgroup_checker
    import pgc_pkg::*;
#(
    parameter int                      N_OUT     = 8,
    parameter int                      N_GRP     = 3,
    parameter int                      GIDX_W    = 4,
    parameter logic [N_OUT*GIDX_W-1:0] GROUP_MAP = 32'h1021_0210,
    parameter bit                      REG_OUT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] func_out,
    input  logic [N_GRP-1:0] check_in,
    output logic [1:0]       rail_out,
    output logic             err_flag
);

    // Group index of one output, as an integer.
    function automatic int grp_of(input int i);
        return int'(GROUP_MAP[i*GIDX_W +: GIDX_W]);
    endfunction

    // Membership mask of group g.
    function automatic logic [N_OUT-1:0] grp_mask(input int g);
        logic [N_OUT-1:0] m;
        for (int i = 0; i < N_OUT; i++) m[i] = (grp_of(i) == g);
        return m;
    endfunction

    // 1 when every index is in range and no group is empty.
    function automatic bit map_valid();
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < N_OUT; i++) begin
            if (grp_of(i) >= N_GRP) ok = 1'b0;
        end
        for (int g = 0; g < N_GRP; g++) begin
            if (grp_mask(g) == '0) ok = 1'b0;
        end
        return ok;
    endfunction

    localparam bit MAP_OK = map_valid();

    generate
        if (!MAP_OK) begin : g_bad_map
            $error("pgroup_checker: GROUP_MAP has an empty group or an index out of range");
        end
    endgenerate

    logic [2*N_GRP-1:0] grp_pairs;
    rail_t              merged;
    logic               err_now;
    logic               err_q;

    genvar g;
    generate
        for (g = 0; g < N_GRP; g++) begin : g_grp
            localparam logic [N_OUT-1:0] MASK = grp_mask(g);
            pgc_group_parity #(
                .N_IN    (N_OUT),
                .MEMBERS (MASK)
            ) u_par (
                .func_in (func_out),
                .chk_in  (check_in[g]),
                .pair    (grp_pairs[2*g +: 2])
            );
        end
    endgenerate

    pgc_rail_tree #(
        .N_LEAF (N_GRP)
    ) u_tree (
        .leaves (grp_pairs),
        .root   (merged)
    );

    assign rail_out = merged;
    assign err_now  = ~rail_valid(merged);

    // Flag register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_now;
    end

    // Select the registered or combinational flag.
    assign err_flag = REG_OUT ? err_q : err_now;

endmodule

// File: rtl/pgroup_checker_sva.sv
// Assertion checker for pgroup_checker, attached through bind.
// Assumes the same GROUP_MAP packing as the checked module.
module pgroup_checker_sva #(
    parameter int                      N_OUT     = 8,
    parameter int                      N_GRP     = 3,
    parameter int                      GIDX_W    = 4,
    parameter logic [N_OUT*GIDX_W-1:0] GROUP_MAP = 32'h1021_0210,
    parameter bit                      REG_OUT   = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] func_out,
    input logic [N_GRP-1:0] check_in,
    input logic [1:0]       rail_out,
    input logic             err_flag
);

    logic all_ok;
    logic rail_ok;

    // Independent view of group consistency taken from the ports.
    always_comb begin
        all_ok = 1'b1;
        for (int g = 0; g < N_GRP; g++) begin
            logic p;
            p = check_in[g];
            for (int i = 0; i < N_OUT; i++) begin
                if (int'(GROUP_MAP[i*GIDX_W +: GIDX_W]) == g) p = p ^ func_out[i];
            end
            if (p) all_ok = 1'b0;
        end
    end

    assign rail_ok = rail_out[1] ^ rail_out[0];

    // R6: merged pair validity matches the parity of every group.
    p_rail_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rail_ok == all_ok);

    // R2: one output flip from a valid state makes the pair invalid.
    p_out_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rail_ok) && $stable(check_in) &&
         $countones(func_out ^ $past(func_out)) == 1) |-> !rail_ok);

    // R3: one check-bit flip from a valid state makes the pair invalid.
    p_chk_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rail_ok) && $stable(func_out) &&
         $countones(check_in ^ $past(check_in)) == 1) |-> !rail_ok);

    // R7: the registered flag follows the previous cycle's pair.
    p_flag_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && $past(rst_n)) |-> (err_flag == !$past(rail_ok)));

    // R7: flag reads 0 on the first cycle out of reset.
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && $rose(rst_n)) |-> !err_flag);

endmodule

bind pgroup_checker pgroup_checker_sva #(
    .N_OUT     (N_OUT),
    .N_GRP     (N_GRP),
    .GIDX_W    (GIDX_W),
    .GROUP_MAP (GROUP_MAP),
    .REG_OUT   (REG_OUT)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_out (func_out),
    .check_in (check_in),
    .rail_out (rail_out),
    .err_flag (err_flag)
);

// File: tb/pgroup_checker_test.sv
// Bench: exhaustive codeword, single-flip and double-flip sweeps on the
// default 8-output, 3-group map (output i in group i mod 3), plus the
// duplication and single-parity extremes on 4 outputs.
module pgroup_checker_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fo = 8'h00;
    logic [2:0] ci = 3'b000;
    logic [1:0] rail;
    logic       err;

    logic [3:0] fd = 4'h0;
    logic [3:0] cd = 4'h0;
    logic [1:0] rail_d;
    logic       err_d;
    logic [0:0] cp = 1'b0;
    logic [1:0] rail_p;
    logic       err_p;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgroup_checker uut (
        .clk (clk), .rst_n (rst_n), .func_out (fo), .check_in (ci),
        .rail_out (rail), .err_flag (err)
    );

    pgroup_checker #(.N_OUT(4), .N_GRP(4), .GIDX_W(4), .GROUP_MAP(16'h3210), .REG_OUT(1'b0)) uut_dup (
        .clk (clk), .rst_n (rst_n), .func_out (fd), .check_in (cd),
        .rail_out (rail_d), .err_flag (err_d)
    );

    pgroup_checker #(.N_OUT(4), .N_GRP(1), .GIDX_W(4), .GROUP_MAP(16'h0000), .REG_OUT(1'b0)) uut_par (
        .clk (clk), .rst_n (rst_n), .func_out (fd), .check_in (cp),
        .rail_out (rail_p), .err_flag (err_p)
    );

    // Reference: check bits of the default map computed arithmetically.
    function automatic logic [2:0] ref_chk(input logic [7:0] f);
        logic [2:0] c;
        c = 3'b000;
        for (int i = 0; i < 8; i++) c[i % 3] = c[i % 3] ^ f[i];
        return c;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one word, check the pair combinationally, then the registered flag.
    task automatic apply(input logic [7:0] f, input logic [2:0] c, input string tag);
        logic exp_bad;
        exp_bad = (ref_chk(f) != c);
        @(negedge clk);
        fo = f;
        ci = c;
        #1;
        check(rail[1] ^ rail[0], !exp_bad, {tag, " R6 rail"});
        @(negedge clk);
        check(err, exp_bad, {tag, " R7 flag"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R7: reset holds the flag at 0 even with an inconsistent word.
        fo = 8'h01;
        ci = 3'b000;
        repeat (3) @(negedge clk);
        check(err, 1'b0, "R7 reset clear");
        rst_n = 1'b1;
        @(negedge clk);
        check(err, 1'b1, "R7 flag after release");
        rst_n = 1'b0;
        @(negedge clk);
        check(err, 1'b0, "R7 reset during error");
        rst_n = 1'b1;

        // R1: every correct codeword is accepted.
        for (int f = 0; f < 256; f++) apply(8'(f), ref_chk(8'(f)), "R1 codeword");

        // R2 and R3: every single flip on an output or a check bit.
        for (int f = 0; f < 256; f++) begin
            for (int b = 0; b < 11; b++) begin
                logic [10:0] w;
                w = {ref_chk(8'(f)), 8'(f)};
                w[b] = ~w[b];
                apply(w[7:0], w[10:8], (b < 8) ? "R2 output flip" : "R3 check flip");
            end
        end

        // R4 and R5: double flips, within one group and across two.
        for (int f = 0; f < 256; f += 17) begin
            for (int a = 0; a < 11; a++) begin
                for (int b = a + 1; b < 11; b++) begin
                    logic [10:0] w;
                    int ga;
                    int gb;
                    w = {ref_chk(8'(f)), 8'(f)};
                    w[a] = ~w[a];
                    w[b] = ~w[b];
                    ga = (a < 8) ? a % 3 : a - 8;
                    gb = (b < 8) ? b % 3 : b - 8;
                    apply(w[7:0], w[10:8], (ga == gb) ? "R4 same-group pair" : "R5 cross-group pair");
                end
            end
        end

        // R8 and R9: duplication and single-parity extremes, exhaustive.
        for (int f = 0; f < 16; f++) begin
            for (int c = 0; c < 16; c++) begin
                fd = 4'(f);
                cd = 4'(c);
                cp = 1'(c);
                #1;
                check(err_d, (f != c), "R8 duplication flag");
                check(rail_d[1] ^ rail_d[0], (f == c), "R8 duplication rail");
                check(err_p, ((^fd) != cp[0]), "R9 single parity flag");
                check(rail_p == {^fd, ~cp[0]}, 1'b1, "R9 leaf pair passthrough");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule